// File: doc/BRIEF.md
# Debug Cycle and Stall Profiling Counters

This block gives a processor two profiling counters behind a small register bus. A wide free-running cycle counter measures elapsed processor clocks. A narrow overhead counter adds up the extra cycles lost to multi-cycle instructions and fetch stalls, which arrive as a per-cycle strobe. Both counters stop while the processor is halted in debug, so a debugger that stops the core does not change the measurement.

Build-time parameters decide whether each counter exists. An absent counter reads as zero and ignores writes. A flag in the control word reports that it is absent, so software can find out what is present. The overhead counter can raise a one-cycle overflow event when it wraps. Turning that event on also clears the counter, so each measurement starts from zero.

The register bus is a plain single-cycle port. A write takes effect at the clock edge where `reg_wr` is high. Read data is a combinational function of `reg_addr` and the current register state. The bus has no handshake and no back-pressure: every access completes in the cycle it is presented.

Top module: `prof_counters`

## Requirements
- R1: After reset, the control word reads 0 apart from the absence flags, both counters read 0, and `ovh_ovf_evt` is low.
- R2: Byte address 0x0 selects the control word, 0x4 the cycle counter and 0x8 the overhead counter. Any other address reads 0.
- R3: When control bit 0 is 1 and `dbg_halted` is low, the cycle counter adds one on every clock edge. After 0xFFFFFFFF it wraps to 0. When bit 0 is 0, the counter holds its value.
- R4: While `dbg_halted` is high, neither counter changes unless it is written.
- R5: A write to 0x4 loads the cycle counter with the written value. The write wins over the increment at that edge.
- R6: The 8-bit overhead counter adds one at each edge where `stall_evt` is high and `dbg_halted` is low. After 0xFF it wraps to 0.
- R7: A control write that changes bit 17 (the overflow event enable) from 0 to 1 sets the overhead counter to 0 at that edge.
- R8: When the overhead counter wraps from 0xFF to 0 by counting while bit 17 is 1, `ovh_ovf_evt` is high for exactly the one cycle in which the counter first reads 0. It stays low when bit 17 is 0.
- R9: With the cycle counter absent, control bit 25 reads 1, bit 0 reads 0, and 0x4 reads 0 even after a write. With the overhead counter absent, bit 24 reads 1, bit 17 reads 0, 0x8 reads 0 even after a write, and `ovh_ovf_evt` stays low.
- R10: A write to 0x8 loads the overhead counter with bits 7:0 of the written value. The write wins over counting and clearing at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe; the write takes effect at this edge |
| reg_addr | input | 4 | Byte address of the register to access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| dbg_halted | input | 1 | High while the processor is halted in debug |
| stall_evt | input | 1 | High for each stall or extra multi-cycle instruction cycle |
| ovh_ovf_evt | output | 1 | One-cycle pulse when the overhead counter wraps with its event enabled |

## Verification
A wrong count or a missed pause shows at the port in the cycle after the faulty edge, because reads are combinational and the counters are compared against a model after every edge. A lost clear or a wrong wrap in the overhead counter shows up both in its read value and as a missing or extra `ovh_ovf_evt` pulse in the same cycle. Once a counter's value is wrong, it stays wrong until software writes it again. A broken absence flag or a leaking write on the stripped-down build shows on the very next read.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int unsigned ADDR_W     = 4;
  localparam logic [3:0]  OFF_CTRL   = 4'h0;
  localparam logic [3:0]  OFF_CYC    = 4'h4;
  localparam logic [3:0]  OFF_OVH    = 4'h8;
  localparam int unsigned BIT_CYC_EN = 0;
  localparam int unsigned BIT_EVT_EN = 17;
  localparam int unsigned BIT_NO_PRF = 24;
  localparam int unsigned BIT_NO_CYC = 25;
endpackage

// File: rtl/pc_cyc_counter.sv
module pc_cyc_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         halt,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (ld)           cnt <= ld_val;
    else if (en && !halt)  cnt <= cnt + 1'b1;
  end

  p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !halt && !ld) |=> cnt == $past(cnt) + 1'b1);
  p_halt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !ld) |=> $stable(cnt));
  p_load_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt == $past(ld_val));
endmodule

// File: rtl/pc_ovh_counter.sv
module pc_ovh_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         halt,
  input  logic         stall,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         clr,
  input  logic         evt_en,
  output logic [W-1:0] cnt,
  output logic         ovf_evt
);
  localparam logic [W-1:0] MAXV = '1;
  logic bump;
  assign bump = stall && !halt && !ld && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      ovf_evt <= 1'b0;
    end else begin
      ovf_evt <= bump && (cnt == MAXV) && evt_en;
      if (ld)        cnt <= ld_val;
      else if (clr)  cnt <= '0;
      else if (bump) cnt <= cnt + 1'b1;
    end
  end

  p_halt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !ld && !clr) |=> $stable(cnt));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ld) |=> cnt == '0);
  p_evt_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> (cnt == '0) && $past(evt_en));
  p_evt_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> !ovf_evt);
  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt == $past(ld_val));
endmodule

// File: rtl/prof_counters.sv
module prof_counters
  import pc_pkg::*;
#(
  parameter bit          HAS_CYC = 1'b1,
  parameter bit          HAS_PRF = 1'b1,
  parameter int unsigned CYC_W   = 32,
  parameter int unsigned OVH_W   = 8,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dbg_halted,
  input  logic              stall_evt,
  output logic              ovh_ovf_evt
);
  logic             cyc_en, evt_en;
  logic             wr_ctrl, wr_cyc, wr_ovh, evt_rise;
  logic [CYC_W-1:0] cyc_val;
  logic [OVH_W-1:0] ovh_val;
  logic             unused_wbits;

  assign unused_wbits = ^reg_wdata;
  assign wr_ctrl  = reg_wr && (reg_addr == OFF_CTRL);
  assign wr_cyc   = reg_wr && (reg_addr == OFF_CYC);
  assign wr_ovh   = reg_wr && (reg_addr == OFF_OVH);
  assign evt_rise = wr_ctrl && reg_wdata[BIT_EVT_EN] && !evt_en && HAS_PRF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_en <= 1'b0;
      evt_en <= 1'b0;
    end else if (wr_ctrl) begin
      cyc_en <= reg_wdata[BIT_CYC_EN] && HAS_CYC;
      evt_en <= reg_wdata[BIT_EVT_EN] && HAS_PRF;
    end
  end

  generate
    if (HAS_CYC) begin : g_cyc
      pc_cyc_counter #(.W(CYC_W)) u_cyc (
        .clk(clk), .rst_n(rst_n), .en(cyc_en), .halt(dbg_halted),
        .ld(wr_cyc), .ld_val(reg_wdata[CYC_W-1:0]), .cnt(cyc_val));
    end else begin : g_no_cyc
      assign cyc_val = '0;
    end
    if (HAS_PRF) begin : g_prf
      pc_ovh_counter #(.W(OVH_W)) u_ovh (
        .clk(clk), .rst_n(rst_n), .halt(dbg_halted), .stall(stall_evt),
        .ld(wr_ovh), .ld_val(reg_wdata[OVH_W-1:0]), .clr(evt_rise),
        .evt_en(evt_en), .cnt(ovh_val), .ovf_evt(ovh_ovf_evt));
    end else begin : g_no_prf
      assign ovh_val     = '0;
      assign ovh_ovf_evt = 1'b0;
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFF_CTRL: begin
        reg_rdata[BIT_CYC_EN] = cyc_en;
        reg_rdata[BIT_EVT_EN] = evt_en;
        reg_rdata[BIT_NO_PRF] = !HAS_PRF;
        reg_rdata[BIT_NO_CYC] = !HAS_CYC;
      end
      OFF_CYC: reg_rdata[CYC_W-1:0] = cyc_val;
      OFF_OVH: reg_rdata[OVH_W-1:0] = ovh_val;
      default: reg_rdata = '0;
    endcase
  end

  p_absent_cyc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!HAS_CYC && reg_addr == OFF_CYC) |-> reg_rdata == '0);
  p_absent_prf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_PRF |-> !ovh_ovf_evt);
  p_ctrl_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> cyc_en == ($past(reg_wdata[BIT_CYC_EN]) && HAS_CYC));
endmodule

// File: tb/tb_prof_counters.sv
`timescale 1ns/100ps
module tb_prof_counters;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic        dbg_halted = 1'b0;
  logic        stall_evt = 1'b0;
  logic [31:0] rdata, rdata_b;
  logic        ovf, ovf_b;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_cyc;
  logic [7:0]  m_ovh;
  logic        m_en, m_evt, m_ovf;

  always #2 clk = ~clk;

  prof_counters dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata), .dbg_halted(dbg_halted),
    .stall_evt(stall_evt), .ovh_ovf_evt(ovf));
  prof_counters #(.HAS_CYC(1'b0), .HAS_PRF(1'b0)) dut_bare (.clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_b),
    .dbg_halted(dbg_halted), .stall_evt(stall_evt), .ovh_ovf_evt(ovf_b));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ctrl(input logic en, input logic evt);
    return (32'(evt) << 17) | 32'(en);
  endfunction

  task automatic rd(input logic [3:0] a, output logic [31:0] v, output logic [31:0] vb);
    reg_addr = a;
    #0.2;
    v = rdata;
    vb = rdata_b;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v, vb;
    rd(4'h0, v, vb); chk({tag, " R2 ctrl"}, v, exp_ctrl(m_en, m_evt));
    chk("R9 bare ctrl flags", vb, 32'h0300_0000);
    rd(4'h4, v, vb); chk({tag, " R3 cyc"}, v, m_cyc);
    chk("R9 bare cyc", vb, 32'h0);
    rd(4'h8, v, vb); chk({tag, " R6 ovh"}, v, {24'h0, m_ovh});
    chk("R9 bare ovh", vb, 32'h0);
    chk({tag, " R8 ovf"}, {31'h0, ovf}, {31'h0, m_ovf});
    chk("R9 bare ovf", {31'h0, ovf_b}, 32'h0);
  endtask

  // Called in the low phase; drives one edge and updates the model.
  task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d,
                      input logic h, input logic s);
    logic clr;
    reg_wr = w; reg_addr = a; reg_wdata = d; dbg_halted = h; stall_evt = s;
    @(posedge clk);
    clr = w && a == 4'h0 && d[17] && !m_evt;
    m_ovf = 1'b0;
    if (w && a == 4'h4) m_cyc = d;
    else if (m_en && !h) m_cyc = m_cyc + 1;
    if (w && a == 4'h8) m_ovh = d[7:0];
    else if (clr) m_ovh = 8'h0;
    else if (s && !h) begin
      m_ovf = (m_ovh == 8'hFF) && m_evt;
      m_ovh = m_ovh + 1;
    end
    if (w && a == 4'h0) begin m_en = d[0]; m_evt = d[17]; end
    @(negedge clk);
    reg_wr = 1'b0; stall_evt = 1'b0; dbg_halted = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, vb;
    void'($urandom(32'd2024));
    m_cyc = 0; m_ovh = 0; m_en = 0; m_evt = 0; m_ovf = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");
    rd(4'hC, v, vb); chk("R2 unmapped", v, 32'h0);

    // R3/R5: enable, load near max, wrap
    step(1, 4'h0, 32'h1, 0, 0);
    step(1, 4'h4, 32'hFFFF_FFFE, 0, 0);
    rd(4'h4, v, vb); chk("R5 load wins", v, 32'hFFFF_FFFE);
    step(0, 4'h0, 0, 0, 0);
    rd(4'h4, v, vb); chk("R3 max", v, 32'hFFFF_FFFF);
    step(0, 4'h0, 0, 0, 0);
    rd(4'h4, v, vb); chk("R3 wrap", v, 32'h0);
    // R4: halt pauses both
    step(1, 4'h8, 32'h10, 0, 0);
    step(0, 4'h0, 0, 1, 1);
    check_all("R4 halt");
    rd(4'h8, v, vb); chk("R4 ovh held", v, 32'h10);
    // R10, R7
    step(1, 4'h8, 32'hABCD_00FE, 0, 1);
    rd(4'h8, v, vb); chk("R10 load", v, 32'hFE);
    step(1, 4'h0, 32'h0002_0001, 0, 1);
    rd(4'h8, v, vb); chk("R7 clear on enable", v, 32'h0);
    // R8: wrap with event enabled
    step(1, 4'h8, 32'hFF, 0, 0);
    step(0, 4'h0, 0, 0, 1);
    chk("R8 pulse", {31'h0, ovf}, 32'h1);
    rd(4'h8, v, vb); chk("R8 wrapped", v, 32'h0);
    step(0, 4'h0, 0, 0, 1);
    chk("R8 one cycle", {31'h0, ovf}, 32'h0);
    // R8: wrap with event disabled
    step(1, 4'h0, 32'h1, 0, 0);
    step(1, 4'h8, 32'hFF, 0, 0);
    step(0, 4'h0, 0, 0, 1);
    chk("R8 no pulse when off", {31'h0, ovf}, 32'h0);
    // R9: writes to bare build
    step(1, 4'h0, 32'hFFFF_FFFF, 0, 0);
    step(1, 4'h4, 32'h1234_5678, 0, 1);
    step(1, 4'h8, 32'h55, 0, 1);
    check_all("R9 after writes");

    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom % 40;
      logic h = ($urandom % 8) == 0;
      logic s = $urandom % 2;
      logic [31:0] d = $urandom;
      if (r == 0)      step(1, 4'h4, (d[0] ? 32'hFFFF_FFF0 : d), h, s);
      else if (r == 1) step(1, 4'h8, d, h, s);
      else if (r == 2) step(1, 4'h0, d & 32'h0002_0001, h, s);
      else             step(0, 4'h0, 0, h, s);
      check_all("rand");
    end
    finish_run();
  end
endmodule